// File: doc/BRIEF.md
# Multiplexed Address/Data External Memory Controller

This block connects an internal memory request port to a byte-wide external memory over a single 8-bit bus. The same bus carries each address byte and then the data byte, one after the other. One active-low strobe does two jobs. Its rising edge latches an address byte into external latches, and while it is low during a read it enables the memory's output driver. A second active-low strobe writes the data. An active-low select line marks the whole access.

A requester offers one access at a time on a valid/ready handshake. The address is sent most significant byte first, one latch phase per byte. The number of address bytes is a parameter. A read then releases the bus and holds the shared strobe low for a set number of wait cycles. A write drives the data under the write strobe instead. Each access ends with a one-cycle completion pulse, and a read returns its byte with that pulse. A mode input shows whether a serial host mode is active. When it is low, no new request is taken, because the pins are shared with the parallel host interface.

Top module: `admux_mem_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, both strobes and the select are high (inactive), the bus is released (`bus_oe` = 0) and `done` is 0.
- R2: `req_ready` is 1 exactly when the controller is idle and `serial_mode` is 1. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1, and the access starts on the pins in the next cycle.
- R3: With `serial_mode` at 0, `req_ready` stays 0, no request is taken and the pins stay idle. Lowering `serial_mode` after a request has been taken does not shorten that access.
- R4: Each address byte, most significant first, takes three cycles. In the first cycle the byte is driven with `oe_n` high. In the second, `oe_n` is low with the byte still driven. In the third, `oe_n` is high again with the same byte driven, so the strobe's rising edge sees stable data. `we_n` stays high throughout.
- R5: After the address, a read releases the bus and holds `oe_n` low, with `we_n` high, for WAIT_CYCLES cycles. The bus is sampled at the end of the last of these cycles, and that byte appears on `rd_data` in the `done` cycle.
- R6: After the address, a write drives `req_wdata` with `we_n` low and `oe_n` high for WAIT_CYCLES cycles. It then keeps the data driven for one more cycle with `we_n` high.
- R7: `mem_sel_n` is low from the first address cycle to the last cycle before `done`. `done` is high for exactly one cycle, with select and both strobes high and the bus released.
- R8: `oe_n` and `we_n` are never low in the same cycle.
- R9: From the cycle after a request is taken until the cycle after `done`, `req_ready` is 0, so a second request waits.
- R10: A read of an address written earlier returns the written byte through the external latch and memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| serial_mode | input | 1 | 1 when a serial host mode allows the memory interface |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8*ADDR_BYTES | Access address |
| req_wdata | input | 8 | Write data |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Read data, valid with `done` on a read |
| bus_out | output | 8 | Value driven on the shared bus |
| bus_oe | output | 1 | 1 = controller drives the bus pads |
| bus_in | input | 8 | Value seen on the bus pads |
| mem_sel_n | output | 1 | External memory select, active low |
| oe_n | output | 1 | Output enable / address latch strobe, active low |
| we_n | output | 1 | Write enable, active low |

## Verification
The bench runs a write followed by a read of the same address. This separates a correct latch sequence from a swapped byte order, because the memory model keys its contents on the latched address. Addresses with all-ones and all-zeros bytes, and data of 00 and FF, expose a lost or stuck bus bit. A read of a location never written, whose value is computed from its address, shows that read data comes from the pins and not from a stale register. A request held through the mode-off period tells whether the mode input only gates acceptance or also cuts a running access short. A request held valid during a busy access checks that only one access is taken at a time.

// File: rtl/admux_pkg.sv
// Shared definitions for the multiplexed address/data memory controller.
// Assumes a byte-wide external bus; the phase type is used by the
// sequencer and the pin decoder.
package admux_pkg;
    localparam int BUS_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ASETUP  = 3'd1,
        ST_ASTROBE = 3'd2,
        ST_AHOLD   = 3'd3,
        ST_RWAIT   = 3'd4,
        ST_WPULSE  = 3'd5,
        ST_WHOLD   = 3'd6,
        ST_FINISH  = 3'd7
    } phase_t;
endpackage

// File: rtl/admux_seq.sv
// Access sequencer: takes one request at a time, steps through the
// address-byte phases (high byte first), then the read wait or write
// pulse, then a single finish cycle. Assumes WAIT_CYCLES >= 1.
module admux_seq
    import admux_pkg::*;
#(
    parameter int ADDR_BYTES  = 2,
    parameter int WAIT_CYCLES = 3,
    localparam int IDX_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             serial_mode,
    input  logic             req_valid,
    input  logic             req_write,
    output logic             req_ready,
    output logic             accept,
    output phase_t           phase,
    output logic [IDX_W-1:0] byte_idx,
    output logic             capture
);
    localparam int CNT_W = $clog2(WAIT_CYCLES + 1);

    logic [CNT_W-1:0] wait_cnt;
    logic             wr_q;

    // Acceptance only from idle and only in a serial host mode.
    always_comb begin
        req_ready = (phase == ST_IDLE) && serial_mode;
        accept    = req_ready && req_valid;
        capture   = (phase == ST_RWAIT) && (wait_cnt == '0);
    end

    // Phase progression, byte index and wait counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= ST_IDLE;
            byte_idx <= '0;
            wait_cnt <= '0;
            wr_q     <= 1'b0;
        end else begin
            case (phase)
                ST_IDLE: begin
                    if (accept) begin
                        phase    <= ST_ASETUP;
                        byte_idx <= IDX_W'(ADDR_BYTES - 1);
                        wr_q     <= req_write;
                    end
                end
                ST_ASETUP:  phase <= ST_ASTROBE;
                ST_ASTROBE: phase <= ST_AHOLD;
                ST_AHOLD: begin
                    if (byte_idx == '0) begin
                        phase    <= wr_q ? ST_WPULSE : ST_RWAIT;
                        wait_cnt <= CNT_W'(WAIT_CYCLES - 1);
                    end else begin
                        byte_idx <= byte_idx - IDX_W'(1);
                        phase    <= ST_ASETUP;
                    end
                end
                ST_RWAIT, ST_WPULSE: begin
                    if (wait_cnt == '0) begin
                        phase <= (phase == ST_RWAIT) ? ST_FINISH : ST_WHOLD;
                    end else begin
                        wait_cnt <= wait_cnt - CNT_W'(1);
                    end
                end
                ST_WHOLD:  phase <= ST_FINISH;
                ST_FINISH: phase <= ST_IDLE;
                default:   phase <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/admux_addr_path.sv
// Request holding registers: stores address and write data when a
// request is taken and presents the address byte chosen by the
// sequencer's byte index. Assumes the index stays below ADDR_BYTES.
module admux_addr_path
    import admux_pkg::*;
#(
    parameter int ADDR_BYTES = 2,
    localparam int IDX_W  = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1,
    localparam int ADDR_W = BUS_W * ADDR_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [BUS_W-1:0]  wdata_in,
    input  logic [IDX_W-1:0]  byte_idx,
    output logic [BUS_W-1:0]  addr_byte,
    output logic [BUS_W-1:0]  wdata_q
);
    logic [ADDR_W-1:0] addr_q;
    logic [BUS_W-1:0]  lane [ADDR_BYTES];

    // Capture the request fields on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (load) begin
            addr_q  <= addr_in;
            wdata_q <= wdata_in;
        end
    end

    // Split the stored address into byte lanes.
    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_lane
        assign lane[g] = addr_q[g*BUS_W +: BUS_W];
    end

    // Pick the lane named by the index.
    always_comb begin
        addr_byte = '0;
        for (int i = 0; i < ADDR_BYTES; i++) begin
            if (byte_idx == IDX_W'(i)) addr_byte = lane[i];
        end
    end
endmodule

// File: rtl/admux_pin_drive.sv
// Pin decoder: turns the current phase into strobe, select and bus
// drive levels, and registers the read byte on the capture cycle.
// Assumes the phase register changes only on the clock edge.
module admux_pin_drive
    import admux_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  phase_t           phase,
    input  logic [BUS_W-1:0] addr_byte,
    input  logic [BUS_W-1:0] wdata,
    input  logic             capture,
    input  logic [BUS_W-1:0] bus_in,
    output logic [BUS_W-1:0] bus_out,
    output logic             bus_oe,
    output logic             mem_sel_n,
    output logic             oe_n,
    output logic             we_n,
    output logic             done,
    output logic [BUS_W-1:0] rd_data
);
    // Decode pin levels for each phase.
    always_comb begin
        bus_out   = '0;
        bus_oe    = 1'b0;
        mem_sel_n = 1'b1;
        oe_n      = 1'b1;
        we_n      = 1'b1;
        done      = 1'b0;
        case (phase)
            ST_ASETUP, ST_AHOLD: begin
                mem_sel_n = 1'b0;
                bus_oe    = 1'b1;
                bus_out   = addr_byte;
            end
            ST_ASTROBE: begin
                mem_sel_n = 1'b0;
                bus_oe    = 1'b1;
                bus_out   = addr_byte;
                oe_n      = 1'b0;
            end
            ST_RWAIT: begin
                mem_sel_n = 1'b0;
                oe_n      = 1'b0;
            end
            ST_WPULSE: begin
                mem_sel_n = 1'b0;
                bus_oe    = 1'b1;
                bus_out   = wdata;
                we_n      = 1'b0;
            end
            ST_WHOLD: begin
                mem_sel_n = 1'b0;
                bus_oe    = 1'b1;
                bus_out   = wdata;
            end
            ST_FINISH: done = 1'b1;
            default: ;
        endcase
    end

    // Hold the byte seen at the end of the last read wait cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else if (capture) rd_data <= bus_in;
    end
endmodule

// File: rtl/admux_mem_ctrl.sv
// Top level of the multiplexed address/data memory controller.
// Connects the sequencer, request holding registers and pin decoder.
// Assumes a pad-level tristate buffer driven by bus_out/bus_oe.
module admux_mem_ctrl
    import admux_pkg::*;
#(
    parameter int ADDR_BYTES  = 2,
    parameter int WAIT_CYCLES = 3,
    localparam int ADDR_W = BUS_W * ADDR_BYTES,
    localparam int IDX_W  = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              serial_mode,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BUS_W-1:0]  req_wdata,
    output logic              done,
    output logic [BUS_W-1:0]  rd_data,
    output logic [BUS_W-1:0]  bus_out,
    output logic              bus_oe,
    input  logic [BUS_W-1:0]  bus_in,
    output logic              mem_sel_n,
    output logic              oe_n,
    output logic              we_n
);
    phase_t             phase;
    logic               accept;
    logic               capture;
    logic [IDX_W-1:0]   byte_idx;
    logic [BUS_W-1:0]   addr_byte;
    logic [BUS_W-1:0]   wdata_q;

    admux_seq #(
        .ADDR_BYTES (ADDR_BYTES),
        .WAIT_CYCLES(WAIT_CYCLES)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .serial_mode(serial_mode),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_ready  (req_ready),
        .accept     (accept),
        .phase      (phase),
        .byte_idx   (byte_idx),
        .capture    (capture)
    );

    admux_addr_path #(
        .ADDR_BYTES(ADDR_BYTES)
    ) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .addr_in  (req_addr),
        .wdata_in (req_wdata),
        .byte_idx (byte_idx),
        .addr_byte(addr_byte),
        .wdata_q  (wdata_q)
    );

    admux_pin_drive u_pins (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase    (phase),
        .addr_byte(addr_byte),
        .wdata    (wdata_q),
        .capture  (capture),
        .bus_in   (bus_in),
        .bus_out  (bus_out),
        .bus_oe   (bus_oe),
        .mem_sel_n(mem_sel_n),
        .oe_n     (oe_n),
        .we_n     (we_n),
        .done     (done),
        .rd_data  (rd_data)
    );
endmodule

// File: rtl/admux_mem_ctrl_chk.sv
// Protocol checker for the memory controller pins and handshake.
// Observes ports only; attached to every instance by the bind below.
module admux_mem_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       serial_mode,
    input logic       req_valid,
    input logic       req_ready,
    input logic       done,
    input logic [7:0] bus_out,
    input logic       bus_oe,
    input logic       mem_sel_n,
    input logic       oe_n,
    input logic       we_n
);
    // R1: pins idle on the first cycle after reset
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (oe_n && we_n && mem_sel_n && !bus_oe && !done));

    // R2: controller is ready again right after completion in serial mode
    a_r2_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (req_ready == serial_mode));

    // R3: no readiness outside serial host mode
    a_r3_blocked_parallel: assert property (@(posedge clk) disable iff (!rst_n)
        !serial_mode |-> !req_ready);

    // R4: address strobe low is followed by a high cycle with the same byte
    a_r4_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n && bus_oe) |=> (oe_n && bus_oe && $stable(bus_out)));

    // R5: read strobe stays low until the access completes
    a_r5_read_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n && !bus_oe) |=> (!oe_n || done));

    // R6: bus driven whenever the write strobe is low
    a_r6_write_driven: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> (bus_oe && oe_n));

    // R6: data held for a cycle after the write strobe rises
    a_r6_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> (bus_oe && $stable(bus_out)));

    // R7: completion lasts one cycle
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: completion cycle has all pins inactive
    a_r7_done_pins_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (mem_sel_n && oe_n && we_n && !bus_oe));

    // R7: select goes low right after a request is taken
    a_r7_select_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !mem_sel_n);

    // R8: strobes never low together
    a_r8_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!oe_n && !we_n));

    // R9: one access at a time
    a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
endmodule

bind admux_mem_ctrl admux_mem_ctrl_chk u_chk (.*);

// File: tb/sim_admux_mem_ctrl.sv
// Bench: behavioural per-cycle reference (queue of expected pin states)
// compared on every falling clock edge, plus an external latch/memory model.
module sim_admux_mem_ctrl;
    localparam int AB = 2;
    localparam int WT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        serial_mode = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, done, bus_oe, mem_sel_n, oe_n, we_n;
    logic [7:0]  rd_data, bus_out, bus_in;

    always #5 clk = ~clk;

    admux_mem_ctrl #(.ADDR_BYTES(AB), .WAIT_CYCLES(WT)) u0 (
        .clk(clk), .rst_n(rst_n), .serial_mode(serial_mode),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .done(done),
        .rd_data(rd_data), .bus_out(bus_out), .bus_oe(bus_oe), .bus_in(bus_in),
        .mem_sel_n(mem_sel_n), .oe_n(oe_n), .we_n(we_n)
    );

    // ---------------- external latch pair and memory model ----------------
    function automatic logic [7:0] seed(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    logic [15:0] ext_latch = '0;
    logic [7:0]  ext_mem [int];

    always @(posedge oe_n) if (rst_n === 1'b1 && bus_oe === 1'b1)
        ext_latch <= {ext_latch[7:0], bus_out};
    always @(posedge we_n) if (rst_n === 1'b1 && bus_oe === 1'b1)
        ext_mem[int'(ext_latch)] = bus_out;

    always_comb begin
        if (!oe_n && !bus_oe && !mem_sel_n)
            bus_in = ext_mem.exists(int'(ext_latch)) ? ext_mem[int'(ext_latch)] : seed(ext_latch);
        else
            bus_in = 8'hFF;
    end

    // ---------------- reference model ----------------
    typedef struct {
        logic sel_n, oe_n, we_n, drv;
        logic [7:0] dat;
        logic done, chk_rd;
        logic [7:0] rd;
        string tag;
    } exp_t;

    exp_t        q[$];
    logic [7:0]  ref_mem [int];
    int          checks = 0;
    int          errors = 0;
    bit          was_idle = 1'b1;
    bit          accepted = 1'b0;
    string       idle_tag = "R1";
    logic        n_rst = 1'b0, n_mode = 1'b1, n_valid = 1'b0, n_write = 1'b0;
    logic [15:0] n_addr = '0;
    logic [7:0]  n_wdata = '0;

    task automatic push(input logic s, o, w, d, input logic [7:0] dt,
                        input logic dn, ck, input logic [7:0] r, input string t);
        exp_t e;
        e.sel_n = s; e.oe_n = o; e.we_n = w; e.drv = d; e.dat = dt;
        e.done = dn; e.chk_rd = ck; e.rd = r; e.tag = t;
        q.push_back(e);
    endtask

    task automatic plan_access(input logic wr, input logic [15:0] a, input logic [7:0] d);
        for (int b = AB - 1; b >= 0; b--) begin
            push(0, 1, 1, 1, a[b*8 +: 8], 0, 0, 8'h00, "R4");
            push(0, 0, 1, 1, a[b*8 +: 8], 0, 0, 8'h00, "R4");
            push(0, 1, 1, 1, a[b*8 +: 8], 0, 0, 8'h00, "R4");
        end
        if (wr) begin
            for (int k = 0; k < WT; k++) push(0, 1, 0, 1, d, 0, 0, 8'h00, "R6");
            push(0, 1, 1, 1, d, 0, 0, 8'h00, "R6");
            push(1, 1, 1, 0, 8'h00, 1, 0, 8'h00, "R7");
            ref_mem[int'(a)] = d;
        end else begin
            for (int k = 0; k < WT; k++) push(0, 0, 1, 0, 8'h00, 0, 0, 8'h00, "R5");
            if (ref_mem.exists(int'(a)))
                push(1, 1, 1, 0, 8'h00, 1, 1, ref_mem[int'(a)], "R10");
            else
                push(1, 1, 1, 0, 8'h00, 1, 1, seed(a), "R5");
        end
    endtask

    task automatic compare_pins();
        exp_t e;
        bit ok;
        if (q.size() == 0) begin
            was_idle = 1'b1;
            e.sel_n = 1; e.oe_n = 1; e.we_n = 1; e.drv = 0; e.dat = 0;
            e.done = 0; e.chk_rd = 0; e.rd = 0; e.tag = idle_tag;
        end else begin
            was_idle = 1'b0;
            e = q.pop_front();
        end
        ok = (mem_sel_n === e.sel_n) && (oe_n === e.oe_n) && (we_n === e.we_n)
          && (bus_oe === e.drv) && (done === e.done);
        if (e.drv && bus_out !== e.dat) ok = 1'b0;
        if (e.chk_rd && rd_data !== e.rd) ok = 1'b0;
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: sel/oe/we/drv/out/done/rd = %b%b%b%b %h %b %h expected %b%b%b%b %h %b %h",
                     e.tag, mem_sel_n, oe_n, we_n, bus_oe, bus_out, done, rd_data,
                     e.sel_n, e.oe_n, e.we_n, e.drv, e.dat, e.done, e.rd);
        end
    endtask

    // One clock: compare, apply staged inputs, check readiness, model acceptance.
    task automatic cycle();
        logic exp_rdy;
        string t;
        @(negedge clk);
        compare_pins();
        rst_n = n_rst; serial_mode = n_mode; req_valid = n_valid;
        req_write = n_write; req_addr = n_addr; req_wdata = n_wdata;
        #1;
        exp_rdy = was_idle && serial_mode;
        t = !serial_mode ? "R3" : (was_idle ? "R2" : "R9");
        if (!rst_n) t = "R1";
        checks++;
        if (req_ready !== exp_rdy) begin
            errors++;
            $display("FAIL %s: req_ready = %b expected %b", t, req_ready, exp_rdy);
        end
        accepted = 1'b0;
        if (rst_n && req_valid && exp_rdy) begin
            plan_access(req_write, req_addr, req_wdata);
            accepted = 1'b1;
        end
    endtask

    task automatic stage(input logic wr, input logic [15:0] a, input logic [7:0] d);
        n_valid = 1'b1; n_write = wr; n_addr = a; n_wdata = d;
    endtask

    task automatic drain();
        n_valid = 1'b0;
        while (q.size() != 0) cycle();
        cycle();
    endtask

    task automatic access(input logic wr, input logic [15:0] a, input logic [7:0] d);
        stage(wr, a, d);
        for (int k = 0; k < 50 && !accepted; k++) cycle();
        drain();
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog: cycles = %0d expected below 20000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        idle_tag = "R1";
        repeat (3) cycle();
        n_rst = 1'b1;
        cycle();
        cycle();
        idle_tag = "R2";

        // R3: request held while parallel host mode is selected
        idle_tag = "R3";
        n_mode = 1'b0;
        stage(1'b1, 16'h7777, 8'h99);
        repeat (6) cycle();
        n_mode = 1'b1;
        idle_tag = "R2";
        for (int k = 0; k < 5 && !accepted; k++) cycle();
        drain();

        // R4 R6 then R10: write and read back
        access(1'b1, 16'h12A4, 8'h5A);
        access(1'b0, 16'h12A4, 8'h00);

        // R5: location never written returns memory contents
        access(1'b0, 16'h00FF, 8'h00);

        // Extreme address and data bytes
        access(1'b1, 16'hFF00, 8'h00);
        access(1'b1, 16'h0001, 8'hFF);
        access(1'b0, 16'hFF00, 8'h00);
        access(1'b0, 16'h0001, 8'h00);
        access(1'b0, 16'h7777, 8'h00);

        // R9: second request held valid during a busy access
        stage(1'b1, 16'hBEEF, 8'hC3);
        for (int k = 0; k < 5 && !accepted; k++) cycle();
        stage(1'b0, 16'hBEEF, 8'h00);
        cycle();
        for (int k = 0; k < 50 && !accepted; k++) cycle();
        drain();

        // R3: mode dropped after acceptance does not cut the access
        stage(1'b0, 16'h3C5A, 8'h00);
        for (int k = 0; k < 5 && !accepted; k++) cycle();
        n_valid = 1'b0;
        n_mode = 1'b0;
        idle_tag = "R3";
        drain();
        n_mode = 1'b1;
        idle_tag = "R2";
        cycle();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule